// File: doc/BRIEF.md
# Per-Pixel Brightness Correction Unit

This unit sits between a host's parallel pixel port and the downstream LED controllers and evens out brightness dot by dot. Every pixel position of the frame owns a 24-bit gain word that holds one 8-bit coefficient per colour. When an incoming pixel arrives, the unit multiplies each 12-bit channel by that position's coefficient, removes the fixed-point scale and clips the result to 12 bits.

The gains live in an external memory that the unit reaches through a read port and a write port. After power-up the host holds the unit in load mode and sends one gain word per pixel position over the same pixel bus. The unit counts positions with frame and line syncs and writes each word to its position's address. It then switches to correct mode and streams live video. In correct mode a separate update port can still rewrite single gains, for example to compensate for LED ageing.

Top module: `pixcal`

## Requirements
- R1: After reset `cr_en`, `cw_en` and `out_valid` are low, and they stay low until a pixel or update is presented.
- R2: Position rules:
  - A `vsync` cycle sets the position to column 0, line 0. It overrides `hsync`.
  - An `hsync` cycle with the column not at 0 moves to column 0 of the next line. An `hsync` cycle at column 0 changes nothing.
  - A sync acts on the pixel presented in the same cycle.
  - Each accepted pixel advances the column. After the last column comes column 0 of the next line, and after the last line comes line 0.
  - The memory address is line*H + column, with defaults H=320 and V=240.
- R3: In correct mode (`load_mode`=0), each cycle with `in_valid` high is followed one cycle later by `cr_en` high, carrying that pixel's address.
- R4: In load mode each valid word produces `cw_en` one cycle later, with no read. `cw_data` = {in_r[7:0], in_g[7:0], in_b[7:0]}.
- R5: Words accepted in load mode never produce `out_valid`.
- R6: Gain word bits [23:16] scale red, bits [15:8] scale green and bits [7:0] scale blue. Each output channel is (pixel*coef)>>7, so 0x80 is unity gain and 0x00 gives zero.
- R7: A scaled channel above 4095 is output as 4095.
- R8: The external memory returns `cr_data` in the cycle after `cr_en`. `out_valid` rises three cycles after the pixel is accepted, and results keep the input order.
- R9: In correct mode, `upd_en` produces `cw_en` one cycle later with `upd_addr` and `upd_coef`. In load mode `upd_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode | input | 1 | 1 = gain load, 0 = correct |
| vsync | input | 1 | Frame start |
| hsync | input | 1 | Line start |
| in_valid | input | 1 | Pixel or gain word present |
| in_r | input | 12 | Red channel, or red gain in the low 8 bits |
| in_g | input | 12 | Green channel, or green gain in the low 8 bits |
| in_b | input | 12 | Blue channel, or blue gain in the low 8 bits |
| upd_en | input | 1 | Runtime gain rewrite request |
| upd_addr | input | 17 | Address to rewrite |
| upd_coef | input | 24 | New gain word |
| cr_en | output | 1 | Gain read request |
| cr_addr | output | 17 | Gain read address |
| cr_data | input | 24 | Gain word returned by the memory |
| cw_en | output | 1 | Gain write request |
| cw_addr | output | 17 | Gain write address |
| cw_data | output | 24 | Gain word to write |
| out_valid | output | 1 | Corrected pixel present |
| out_r | output | 12 | Corrected red |
| out_g | output | 12 | Corrected green |
| out_b | output | 12 | Corrected blue |

## Verification
Timing is counted from the cycle in which a pixel or word is driven:
- A read request or write request is due one cycle later.
- A corrected pixel is due three cycles later, one register stage, then the memory's own stage, then the output register.

The bench stamps each expected event with its due cycle and puts it in a queue per port. Every cycle, half a period after the clock edge, it compares the port against the head of that queue. An early, late or missing event therefore fails in the exact cycle it was due.

// File: rtl/pixcal.sv
module pixcal #(
  parameter int H      = 320,
  parameter int V      = 240,
  parameter int PIX_W  = 12,
  parameter int COEF_W = 8,
  parameter int FRAC   = 7,
  localparam int N     = H * V,
  localparam int AW    = $clog2(N),
  localparam int CW    = 3 * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_mode,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  input  logic              upd_en,
  input  logic [AW-1:0]     upd_addr,
  input  logic [CW-1:0]     upd_coef,
  output logic              cr_en,
  output logic [AW-1:0]     cr_addr,
  input  logic [CW-1:0]     cr_data,
  output logic              cw_en,
  output logic [AW-1:0]     cw_addr,
  output logic [CW-1:0]     cw_data,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  localparam int XW   = $clog2(H);
  localparam int YW   = $clog2(V);
  localparam int PW   = PIX_W + COEF_W;
  localparam int MAXV = (1 << PIX_W) - 1;

  logic [XW-1:0] x_q, x_s, x_n;
  logic [YW-1:0] y_q, y_s, y_n;
  logic [AW-1:0] pos_addr;
  logic          s2_v;
  logic [3*PIX_W-1:0] s1_pix, s2_pix, res, out_pix;

  function automatic logic [YW-1:0] next_line(input logic [YW-1:0] y);
    return (y == YW'(V - 1)) ? '0 : y + YW'(1);
  endfunction

  always_comb begin
    x_s = x_q;
    y_s = y_q;
    if (vsync) begin
      x_s = '0;
      y_s = '0;
    end else if (hsync && x_q != '0) begin
      x_s = '0;
      y_s = next_line(y_q);
    end
    x_n = x_s;
    y_n = y_s;
    if (in_valid) begin
      if (x_s == XW'(H - 1)) begin
        x_n = '0;
        y_n = next_line(y_s);
      end else begin
        x_n = x_s + XW'(1);
      end
    end
  end

  assign pos_addr = AW'(int'(y_s) * H + int'(x_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q       <= '0;
      y_q       <= '0;
      cr_en     <= 1'b0;
      cw_en     <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      x_q       <= x_n;
      y_q       <= y_n;
      cr_en     <= in_valid && !load_mode;
      cw_en     <= load_mode ? in_valid : upd_en;
      s2_v      <= cr_en;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    cr_addr <= pos_addr;
    s1_pix  <= {in_r, in_g, in_b};
    s2_pix  <= s1_pix;
    out_pix <= res;
    if (load_mode) begin
      cw_addr <= pos_addr;
      cw_data <= {in_r[COEF_W-1:0], in_g[COEF_W-1:0], in_b[COEF_W-1:0]};
    end else begin
      cw_addr <= upd_addr;
      cw_data <= upd_coef;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [PW-1:0] prod, sh;
    assign prod = PW'(s2_pix[c*PIX_W +: PIX_W]) * PW'(cr_data[c*COEF_W +: COEF_W]);
    assign sh   = prod >> FRAC;
    assign res[c*PIX_W +: PIX_W] = (sh > PW'(MAXV)) ? '1 : sh[PIX_W-1:0];
  end

  assign out_r = out_pix[2*PIX_W +: PIX_W];
  assign out_g = out_pix[PIX_W +: PIX_W];
  assign out_b = out_pix[0 +: PIX_W];
endmodule

// File: rtl/pixcal_chk.sv
module pixcal_chk #(
  parameter int H = 320,
  parameter int V = 240,
  localparam int N  = H * V,
  localparam int AW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_mode,
  input logic          vsync,
  input logic          in_valid,
  input logic          upd_en,
  input logic [AW-1:0] upd_addr,
  input logic          cr_en,
  input logic [AW-1:0] cr_addr,
  input logic          cw_en,
  input logic [AW-1:0] cw_addr,
  input logic          out_valid
);
  // R2
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_en |-> int'(cr_addr) < N);
  // R2
  frame_start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync && in_valid && !load_mode |=> cr_addr == '0);
  // R4
  load_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode && in_valid |=> cw_en && !cr_en && int'(cw_addr) < N);
  // R8
  out_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_en |=> ##1 out_valid);
  // R8
  out_has_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cr_en, 2));
  // R9
  update_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mode && upd_en |=> cw_en && cw_addr == $past(upd_addr));
endmodule

bind pixcal pixcal_chk #(.H(H), .V(V)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .vsync(vsync),
  .in_valid(in_valid), .upd_en(upd_en), .upd_addr(upd_addr),
  .cr_en(cr_en), .cr_addr(cr_addr), .cw_en(cw_en), .cw_addr(cw_addr),
  .out_valid(out_valid)
);

// File: tb/pixcal_tb_top.sv
`timescale 1ns/1ps
module pixcal_tb_top;
  localparam int BH = 20, BV = 12, BN = BH * BV, BAW = $clog2(BN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_mode = 1'b0, vsync = 1'b0, hsync = 1'b0, in_valid = 1'b0, upd_en = 1'b0;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0;
  logic [BAW-1:0] upd_addr = '0;
  logic [23:0] upd_coef = '0;
  logic cr_en, cw_en, out_valid;
  logic [BAW-1:0] cr_addr, cw_addr;
  logic [23:0] cr_data, cw_data;
  logic [11:0] out_r, out_g, out_b;
  logic [23:0] mem [BN];

  always #2.5 clk = ~clk;

  pixcal #(.H(BH), .V(BV)) dut_i (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BN; i++) mem[i] <= '0;
      cr_data <= '0;
    end else begin
      if (cw_en) mem[cw_addr] <= cw_data;
      if (cr_en) cr_data <= mem[cr_addr];
    end
  end

  int nchk = 0, nfail = 0, cyc = 0, bx = 0, by = 0;
  bit done = 0;
  logic [23:0] shadow [BN];
  int rq_due[$], rq_addr[$], wq_due[$], wq_addr[$], oq_due[$];
  logic [23:0] wq_data[$];
  logic [35:0] oq_pix[$];
  string wq_tag[$], oq_tag[$];
  logic lm_d1 = 0, lm_d2 = 0, lm_d3 = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int sref(input int p, input int c);
    int v = (p * c) >> 7;
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic check_ports();
    bit e;
    e = rq_due.size() > 0 && rq_due[0] == cyc;
    chk(cr_en === e, "R3", "cr_en", cr_en, e);
    if (e) begin
      if (cr_en) chk(int'(cr_addr) == rq_addr[0], "R2", "cr_addr", cr_addr, rq_addr[0]);
      void'(rq_due.pop_front()); void'(rq_addr.pop_front());
    end
    e = wq_due.size() > 0 && wq_due[0] == cyc;
    chk(cw_en === e, e ? wq_tag[0] : "R9", "cw_en", cw_en, e);
    if (e) begin
      if (cw_en) begin
        chk(int'(cw_addr) == wq_addr[0], wq_tag[0], "cw_addr", cw_addr, wq_addr[0]);
        chk(cw_data == wq_data[0], wq_tag[0], "cw_data", cw_data, wq_data[0]);
      end
      void'(wq_due.pop_front()); void'(wq_addr.pop_front());
      void'(wq_data.pop_front()); void'(wq_tag.pop_front());
    end
    e = oq_due.size() > 0 && oq_due[0] == cyc;
    chk(out_valid === e, lm_d3 ? "R5" : "R8", "out_valid", out_valid, e);
    if (e) begin
      if (out_valid) chk({out_r, out_g, out_b} == oq_pix[0], oq_tag[0], "pixel",
                         {out_r, out_g, out_b}, oq_pix[0]);
      void'(oq_due.pop_front()); void'(oq_pix.pop_front()); void'(oq_tag.pop_front());
    end
  endtask

  task automatic step(input bit lm, input bit vs, input bit hs, input bit v,
                      input int r, input int g, input int b,
                      input bit ue = 0, input int ua = 0, input logic [23:0] uc = '0);
    int addr;
    @(negedge clk);
    cyc++;
    if (!done) check_ports();
    lm_d3 = lm_d2; lm_d2 = lm_d1; lm_d1 = lm;
    load_mode = lm; vsync = vs; hsync = hs; in_valid = v;
    in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
    upd_en = ue; upd_addr = BAW'(ua); upd_coef = uc;
    if (vs) begin bx = 0; by = 0; end
    else if (hs && bx != 0) begin bx = 0; by = (by == BV - 1) ? 0 : by + 1; end
    addr = by * BH + bx;
    if (v) begin
      bx++;
      if (bx == BH) begin bx = 0; by = (by == BV - 1) ? 0 : by + 1; end
    end
    if (v && !lm) begin
      int cr = shadow[addr][23:16], cg = shadow[addr][15:8], cb = shadow[addr][7:0];
      bit sat = ((r * cr) >> 7) > 4095 || ((g * cg) >> 7) > 4095 || ((b * cb) >> 7) > 4095;
      rq_due.push_back(cyc + 1); rq_addr.push_back(addr);
      oq_due.push_back(cyc + 3);
      oq_pix.push_back({12'(sref(r, cr)), 12'(sref(g, cg)), 12'(sref(b, cb))});
      oq_tag.push_back(sat ? "R7" : "R6");
    end
    if (v && lm) begin
      logic [23:0] w = {8'(r), 8'(g), 8'(b)};
      wq_due.push_back(cyc + 1); wq_addr.push_back(addr);
      wq_data.push_back(w); wq_tag.push_back("R4"); shadow[addr] = w;
    end else if (!lm && ue) begin
      wq_due.push_back(cyc + 1); wq_addr.push_back(ua);
      wq_data.push_back(uc); wq_tag.push_back("R9"); shadow[ua] = uc;
    end
  endtask

  task automatic idle(input bit lm, input int n);
    for (int i = 0; i < n; i++) step(lm, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_frame(input bit lm);
    for (int a = 0; a < BN; a++) begin
      int r = $urandom % 4096, g = $urandom % 4096, b = $urandom % 4096;
      bit hs = (a % BH == 0) && ($urandom % 2 == 1);
      while ($urandom % 4 == 0) step(lm, 0, 0, 0, 0, 0, 0);
      if (lm) begin
        if (a == 0) begin r = 'h80; g = 'h80; b = 'h80; end
        if (a == 1) begin r = 'h00; g = 'hFF; b = 'h80; end
        if (a == 2) begin r = 'hFF; g = 'hFF; b = 'hFF; end
      end else if (a < 3) begin
        r = (a == 2) ? 3000 : 4095; g = r; b = r;
      end
      step(lm, a == 0, hs, 1, r, g, b);
    end
  endtask

  function automatic void summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < BN; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(!cr_en && !cw_en && !out_valid, "R1", "idle outputs", {cr_en, cw_en, out_valid}, 0);
    // R4, R5, R9: load gains, with an update attempt that must be ignored
    run_frame(1);
    step(1, 0, 0, 0, 0, 0, 0, 1, 3, 24'h123456);
    idle(1, 2);
    idle(0, 3);
    // R6, R7, R2, R3, R8: corrected frame
    run_frame(0);
    idle(0, 4);
    // R2: early hsync, standalone hsync, combined syncs, wrap without syncs
    step(0, 1, 0, 1, 100, 200, 300);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, $urandom % 4096, 777, 4095);
    step(0, 0, 1, 1, 4095, 1, 2048);
    step(0, 0, 0, 1, 11, 22, 33);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 500, 600, 700);
    step(0, 1, 1, 1, 4095, 4095, 4095);
    for (int i = 0; i < BN + 3; i++) step(0, 0, 0, 1, $urandom % 4096, $urandom % 4096, $urandom % 4096);
    idle(0, 4);
    // R9: runtime rewrites, one alongside a live pixel
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 24'h40FF00);
    step(0, 0, 0, 0, 0, 0, 0, 1, BN - 1, 24'hFF0080);
    step(0, 0, 0, 0, 0, 0, 0, 1, 7, 24'h808080);
    step(0, 1, 0, 1, 4095, 4095, 4095, 1, 50, 24'h010203);
    idle(0, 4);
    run_frame(0);
    idle(0, 8);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule